// File: doc/BRIEF.md
# Cache-Line-Crossing Request Splitter

This block turns one vector memory operation into a stream of line-contained memory requests. It captures a start command carrying one address per lane, an active-lane mask, the element size (as a power of two), the element count and the operation kind. It then walks the active lanes from the lowest index upward and emits one request per lane. When a lane's byte range reaches past the end of the cache line that holds its first byte, the block emits two requests for that lane: a head piece up to the line boundary and a tail piece from the boundary onward.

Each request carries its address, its byte length, the originating lane, the byte offset into a packed per-lane data buffer and the operation kind. Requests leave on a valid/ready handshake. For as long as a run is active and until the next start, the block also reports how many requests each lane produces. A scalar mode treats lane 0's address as a single access and ignores the mask.

When the last request of a run is accepted, the block raises a one-cycle done pulse. A run with no active lanes finishes with a done pulse and no requests.

Top module: `line_split_issuer`

## Requirements
- R1: While reset is held and right after it, `req_valid_o`, `done_o` and `busy_o` are 0 and every per-lane count and the scalar count are 0.
- R2: The byte size of a read (op 0) or write (op 1) is element count times 2^`elem_log2_i`. An atomic (op 2) uses 2^`elem_log2_i` bytes, whatever the count.
- R3: A lane whose last byte (address + size - 1) is in the same line as its first byte gives exactly one request, with the lane's address and the full size.
- R4: Let B be the line base of a lane's last byte. If B is greater than the lane's address, the lane gives two requests back to back. The first has the lane address and length B - address. The second has address B and length size - (B - address). No request ever covers bytes of two lines.
- R5: Each request's data offset is lane × size bytes. The tail piece of a split lane adds the head piece's length to that.
- R6: Requests leave in ascending lane order, and lanes whose mask bit is 0 produce nothing.
- R7: From the cycle after an accepted start, `lane_cnt_o[2l+1:2l]` holds 2 for a split active lane, 1 for an unsplit active lane and 0 for an inactive lane.
- R8: In scalar mode only lane 0's address is used and the mask is ignored. Requests carry lane 0, all per-lane counts are 0, and `scalar_cnt_o` holds 1, or 2 when the access is split. Outside scalar mode `scalar_cnt_o` is 0.
- R9: While `req_valid_o` is 1 and `req_ready_i` is 0, the address, length, lane and offset hold steady.
- R10: `done_o` is high for exactly one cycle, one cycle after the last request is accepted, with `busy_o` and `req_valid_o` low. With a zero mask in vector mode, `done_o` is high in the cycle after start and no request appears.
- R11: A start raised while the block is busy is ignored. The requests and counts of the run in progress are unchanged.
- R12: `req_op_o` repeats the operation captured at start, coded 0 read, 1 write, 2 atomic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture a new operation (taken only when idle) |
| scalar_i | input | 1 | Scalar mode: single access at lane 0's address |
| op_i | input | 2 | Operation: 0 read, 1 write, 2 atomic |
| elem_log2_i | input | 2 | log2 of element size in bytes |
| elem_cnt_i | input | CNT_W | Elements per lane, 1..MAX_CNT |
| mask_i | input | LANES | Active-lane mask |
| addr_i | input | LANES*ADDR_W | Lane addresses, lane l at bits [l*ADDR_W +: ADDR_W] |
| busy_o | output | 1 | Requests of a run still pending |
| req_valid_o | output | 1 | Request available |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | LEN_W | Request length in bytes |
| req_lane_o | output | LANE_W | Originating lane |
| req_off_o | output | OFF_W | Byte offset into the lane data buffer |
| req_op_o | output | 2 | Operation of the request |
| lane_cnt_o | output | 2*LANES | Per-lane request counts, 2 bits each |
| scalar_cnt_o | output | 2 | Scalar-mode request count |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The sweep places lane start addresses at every few byte positions within a line, across all element sizes, counts and operation kinds. This hits the case where the last byte lands exactly on the final byte of a line. A design that compared line bases with the wrong bound would split that lane and emit a zero-length tail. Atomics with large counts check that the size rule ignores the count. A design that didn't would split lanes that fit, and report counts of 2. Throttling ready on a fixed pattern exposes a design that advances to the tail piece or the next lane without a handshake, or that changes fields while stalled. Zero masks, scalar runs with a mask that should be ignored, and a start injected mid-run catch a design that never pulses done, reads mask bits in scalar mode, or recaptures inputs while busy.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_ATOMIC = 2'd2
  } lsplit_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } lsplit_state_e;

endpackage

// File: rtl/lsplit_line_calc.sv
// Per-lane line-crossing test: where the access splits and how long each piece is.
module lsplit_line_calc #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32,
  parameter int LEN_W      = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  size_i,
  output logic              cross_o,
  output logic [ADDR_W-1:0] split_o,
  output logic [LEN_W-1:0]  head_o,
  output logic [LEN_W-1:0]  tail_o
);
  localparam int LINE_W = $clog2(LINE_BYTES);

  logic [ADDR_W:0] last_byte;
  logic [ADDR_W:0] last_base;

  always_comb begin
    last_byte = {1'b0, addr_i} + (ADDR_W+1)'(size_i) - (ADDR_W+1)'(1);
    last_base = {last_byte[ADDR_W:LINE_W], {LINE_W{1'b0}}};
    cross_o   = (last_base > {1'b0, addr_i});
    split_o   = last_base[ADDR_W-1:0];
    // The split point is always the next line boundary above the start.
    head_o    = cross_o ? (LEN_W'(LINE_BYTES) - LEN_W'(addr_i[LINE_W-1:0])) : size_i;
    tail_o    = cross_o ? (size_i - head_o) : '0;
  end
endmodule

// File: rtl/lsplit_lane_pick.sv
// Lowest-index pending lane and the pending set with that lane removed.
module lsplit_lane_pick #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic [LANES-1:0]  pend_i,
  output logic [LANE_W-1:0] idx_o,
  output logic [LANES-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = LANE_W'(i);
    end
    rest_o = pend_i & (pend_i - LANES'(1));
  end
endmodule

// File: rtl/line_split_issuer.sv
module line_split_issuer
  import lsplit_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32,
  parameter int MAX_CNT    = 4,
  localparam int CNT_W     = $clog2(MAX_CNT + 1),
  localparam int LEN_W     = $clog2(LINE_BYTES + 1),
  localparam int MAX_BYTES = MAX_CNT * 8,
  localparam int OFF_W     = $clog2(LANES * MAX_BYTES),
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     scalar_i,
  input  logic [1:0]               op_i,
  input  logic [1:0]               elem_log2_i,
  input  logic [CNT_W-1:0]         elem_cnt_i,
  input  logic [LANES-1:0]         mask_i,
  input  logic [LANES*ADDR_W-1:0]  addr_i,
  output logic                     busy_o,
  output logic                     req_valid_o,
  input  logic                     req_ready_i,
  output logic [ADDR_W-1:0]        req_addr_o,
  output logic [LEN_W-1:0]         req_len_o,
  output logic [LANE_W-1:0]        req_lane_o,
  output logic [OFF_W-1:0]         req_off_o,
  output logic [1:0]               req_op_o,
  output logic [2*LANES-1:0]       lane_cnt_o,
  output logic [1:0]               scalar_cnt_o,
  output logic                     done_o
);

  // A request may reach at most one line boundary.
  if (MAX_BYTES > LINE_BYTES) begin : g_bad_size
    $error("largest request exceeds the cache-line size");
  end
  if ((1 << $clog2(LINE_BYTES)) != LINE_BYTES) begin : g_bad_line
    $error("line size must be a power of two");
  end

  // ---------------- captured operation ----------------
  lsplit_state_e           state_q, state_d;
  logic [LANES*ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]        mask_q, mask_d;
  logic [LANES-1:0]        pend_q, pend_d;
  logic [LEN_W-1:0]        size_q, size_d;
  lsplit_op_e              op_q, op_d;
  logic                    scalar_q, scalar_d;
  logic                    half_q, half_d;
  logic                    done_q, done_d;
  logic                    cap_en;

  // ---------------- per-lane split information ----------------
  logic              cross_v [LANES];
  logic [ADDR_W-1:0] split_v [LANES];
  logic [LEN_W-1:0]  head_v  [LANES];
  logic [LEN_W-1:0]  tail_v  [LANES];
  logic [1:0]        cnt_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lsplit_line_calc #(
      .ADDR_W    (ADDR_W),
      .LINE_BYTES(LINE_BYTES),
      .LEN_W     (LEN_W)
    ) u_calc (
      .addr_i (addr_q[g*ADDR_W +: ADDR_W]),
      .size_i (size_q),
      .cross_o(cross_v[g]),
      .split_o(split_v[g]),
      .head_o (head_v[g]),
      .tail_o (tail_v[g])
    );
    assign cnt_arr[g] = (scalar_q || !mask_q[g]) ? 2'd0 : (cross_v[g] ? 2'd2 : 2'd1);
    assign lane_cnt_o[2*g +: 2] = cnt_arr[g];
  end

  assign scalar_cnt_o = !scalar_q ? 2'd0 : (cross_v[0] ? 2'd2 : 2'd1);

  // ---------------- lane selection ----------------
  logic [LANE_W-1:0] cur;
  logic [LANES-1:0]  pend_rest;

  lsplit_lane_pick #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_pick (
    .pend_i(pend_q),
    .idx_o (cur),
    .rest_o(pend_rest)
  );

  logic              cur_cross;
  logic [ADDR_W-1:0] cur_addr;
  logic [OFF_W-1:0]  lane_base;
  logic              fire;
  logic              last_piece;

  always_comb begin
    cur_cross  = cross_v[cur];
    cur_addr   = addr_q[cur*ADDR_W +: ADDR_W];
    lane_base  = OFF_W'(cur) * OFF_W'(size_q);
    fire       = req_valid_o && req_ready_i;
    last_piece = !(cur_cross && !half_q);
  end

  assign req_valid_o = (state_q == ST_ISSUE);
  assign busy_o      = (state_q == ST_ISSUE);
  assign req_addr_o  = half_q ? split_v[cur] : cur_addr;
  assign req_len_o   = half_q ? tail_v[cur] : head_v[cur];
  assign req_lane_o  = cur;
  assign req_off_o   = lane_base + (half_q ? OFF_W'(head_v[cur]) : OFF_W'(0));
  assign req_op_o    = op_q;
  assign done_o      = done_q;

  // ---------------- next state ----------------
  always_comb begin
    cap_en   = (state_q == ST_IDLE) && start_i;
    state_d  = state_q;
    addr_d   = addr_q;
    mask_d   = mask_q;
    pend_d   = pend_q;
    size_d   = size_q;
    op_d     = op_q;
    scalar_d = scalar_q;
    half_d   = half_q;
    done_d   = 1'b0;

    if (cap_en) begin
      addr_d   = addr_i;
      mask_d   = mask_i;
      op_d     = lsplit_op_e'(op_i);
      scalar_d = scalar_i;
      half_d   = 1'b0;
      size_d   = (lsplit_op_e'(op_i) == OP_ATOMIC)
                 ? (LEN_W'(1) << elem_log2_i)
                 : (LEN_W'(elem_cnt_i) << elem_log2_i);
      pend_d   = scalar_i ? LANES'(1) : mask_i;
      if (scalar_i || (mask_i != '0)) begin
        state_d = ST_ISSUE;
      end else begin
        done_d  = 1'b1;
      end
    end else if (fire) begin
      if (!last_piece) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        pend_d = pend_rest;
        if (pend_rest == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      mask_q   <= '0;
      pend_q   <= '0;
      size_q   <= LEN_W'(1);
      op_q     <= OP_READ;
      scalar_q <= 1'b0;
      half_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      half_q  <= half_d;
      done_q  <= done_d;
      if (cap_en) begin
        addr_q   <= addr_d;
        mask_q   <= mask_d;
        size_q   <= size_d;
        op_q     <= op_d;
        scalar_q <= scalar_d;
      end
    end
  end

  // ---------------- assertions ----------------
  // R4
  no_line_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (int'(req_addr_o[$clog2(LINE_BYTES)-1:0]) + int'(req_len_o) <= LINE_BYTES)
                    && (req_len_o != '0));

  // R4
  tail_follows_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_piece) |=> req_valid_o && (req_lane_o == $past(req_lane_o))
                              && (req_addr_o > $past(req_addr_o)));

  // R6
  lane_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_piece && (pend_rest != '0)) |=> req_valid_o && (req_lane_o > $past(req_lane_o)));

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o)
                                      && $stable(req_lane_o) && $stable(req_off_o));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o && !busy_o);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  issued_lane_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !scalar_q) |-> (cnt_arr[cur] != 2'd0));

endmodule

// File: tb/test_line_split_issuer.sv
module test_line_split_issuer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int ADDR_W = 16;
  localparam int LINE = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, scalar_i, req_ready_i;
  logic [1:0]  op_i, elem_log2_i;
  logic [2:0]  elem_cnt_i;
  logic [3:0]  mask_i;
  logic [63:0] addr_i;
  logic        busy_o, req_valid_o, done_o;
  logic [15:0] req_addr_o;
  logic [5:0]  req_len_o;
  logic [1:0]  req_lane_o, req_op_o, scalar_cnt_o;
  logic [6:0]  req_off_o;
  logic [7:0]  lane_cnt_o;

  line_split_issuer i_line_split_issuer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_i(scalar_i),
    .op_i(op_i), .elem_log2_i(elem_log2_i), .elem_cnt_i(elem_cnt_i),
    .mask_i(mask_i), .addr_i(addr_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .req_lane_o(req_lane_o),
    .req_off_o(req_off_o), .req_op_o(req_op_o), .lane_cnt_o(lane_cnt_o),
    .scalar_cnt_o(scalar_cnt_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  int ta [4];
  int ea [8], el [8], eln [8], eo [8];
  int ecnt [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [3:0] m, input int e, input int c,
                          input int op, input bit sc, input bit inj);
    int n = 0;
    int scnt = 0;
    int idx = 0;
    int cyc = 0;
    bit hold = 0;
    logic [15:0] s_addr; logic [5:0] s_len; logic [1:0] s_lane; logic [6:0] s_off;
    for (int l = 0; l < 4; l++) begin
      bit act = sc ? (l == 0) : m[l];
      int size = (op == 2) ? (1 << e) : (c << e);
      int last = ta[l] + size - 1;
      int sp = last - (last % LINE);
      ecnt[l] = 0;
      if (act) begin
        if (sp > ta[l]) begin
          ea[n] = ta[l]; el[n] = sp - ta[l]; eln[n] = l; eo[n] = l * size; n++;
          ea[n] = sp; el[n] = size - (sp - ta[l]); eln[n] = l;
          eo[n] = l * size + (sp - ta[l]); n++;
          ecnt[l] = 2;
        end else begin
          ea[n] = ta[l]; el[n] = size; eln[n] = l; eo[n] = l * size; n++;
          ecnt[l] = 1;
        end
      end
    end
    if (sc) begin scnt = ecnt[0]; ecnt[0] = 0; end

    start_i = 1'b1; scalar_i = sc; op_i = 2'(op); elem_log2_i = 2'(e);
    elem_cnt_i = 3'(c); mask_i = m;
    for (int l = 0; l < 4; l++) addr_i[l*16 +: 16] = 16'(ta[l]);
    @(negedge clk);
    start_i = 1'b0;
    for (int l = 0; l < 4; l++)
      chk(lane_cnt_o[2*l +: 2] == 2'(ecnt[l]), sc ? "R8" : "R7", "lane count",
          lane_cnt_o[2*l +: 2], ecnt[l]);
    chk(scalar_cnt_o == 2'(scnt), "R8", "scalar count", scalar_cnt_o, scnt);
    if (n == 0) begin
      chk(done_o && !req_valid_o, "R10", "empty-mask done", done_o, 1);
      @(negedge clk);
      chk(!done_o && !req_valid_o, "R10", "empty-mask done width", done_o, 0);
      return;
    end
    while (idx < n && cyc < 200) begin
      req_ready_i = ((cyc % 3) != 1);
      if (inj && cyc == 0) begin start_i = 1'b1; mask_i = ~m; scalar_i = ~sc; end
      if (hold) begin
        chk(req_valid_o && req_addr_o == s_addr && req_len_o == s_len &&
            req_lane_o == s_lane && req_off_o == s_off, "R9", "hold while stalled",
            req_addr_o, s_addr);
      end
      if (req_valid_o && req_ready_i) begin
        chk(req_addr_o == 16'(ea[idx]), (el[idx] != ((op == 2) ? (1 << e) : (c << e)))
            ? "R4" : "R3", "address", req_addr_o, ea[idx]);
        chk(req_len_o == 6'(el[idx]), (ecnt[eln[idx]] == 2 || (sc && scnt == 2)) ? "R4"
            : ((op == 2) ? "R2" : "R3"), "length", req_len_o, el[idx]);
        chk(req_lane_o == 2'(eln[idx]), sc ? "R8" : "R6", "lane", req_lane_o, eln[idx]);
        chk(req_off_o == 7'(eo[idx]), "R5", "offset", req_off_o, eo[idx]);
        chk(req_op_o == 2'(op), "R12", "op", req_op_o, op);
        idx++;
      end
      hold = req_valid_o && !req_ready_i;
      s_addr = req_addr_o; s_len = req_len_o; s_lane = req_lane_o; s_off = req_off_o;
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    chk(idx == n, "R6", "request count", idx, n);
    chk(done_o && !req_valid_o && !busy_o, "R10", "done after last", done_o, 1);
    if (inj) begin
      for (int l = 0; l < 4; l++)
        chk(lane_cnt_o[2*l +: 2] == 2'(ecnt[l]), "R11", "counts kept",
            lane_cnt_o[2*l +: 2], ecnt[l]);
      chk(scalar_cnt_o == 2'(scnt), "R11", "scalar count kept", scalar_cnt_o, scnt);
    end
    @(negedge clk);
    chk(!done_o, "R10", "done one cycle", done_o, 0);
    chk(!req_valid_o, "R11", "no extra run", req_valid_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; scalar_i = 1'b0; req_ready_i = 1'b0;
    op_i = '0; elem_log2_i = '0; elem_cnt_i = 3'd1; mask_i = '0; addr_i = '0;
    repeat (3) @(negedge clk);
    chk(!req_valid_o && !done_o && !busy_o, "R1", "outputs in reset", req_valid_o, 0);
    chk(lane_cnt_o == '0 && scalar_cnt_o == '0, "R1", "counts in reset", lane_cnt_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && !done_o && !busy_o, "R1", "outputs after reset", req_valid_o, 0);

    for (int e = 0; e < 4; e++)
      for (int c = 1; c <= 4; c++)
        for (int op = 0; op < 3; op++)
          for (int o = 0; o < 32; o += 3) begin
            for (int l = 0; l < 4; l++) ta[l] = 'h100 + l * 'h40 + ((o + l * 9) % 32);
            run_case(4'((o * 5 + c) % 16), e, c, op, 1'b0, (o == 3));
          end
    for (int e = 0; e < 4; e++)
      for (int c = 1; c <= 4; c++)
        for (int o = 0; o < 32; o++) begin
          ta[0] = 'h2000 + o; ta[1] = 'h10; ta[2] = 'h3f; ta[3] = 'h5e;
          run_case(4'(o % 16), e, c, o % 3, 1'b1, (o == 7));
        end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule